// File: doc/BRIEF.md
# Bus Controller Descriptor Sequencer

This block drives bus-controller message traffic for a MIL-STD-1553 host interface. Each message is described by a four-word entry in a descriptor stack held in shared memory. Word 0 is the block status word. Word 1 holds the time tag. Word 3 holds the data block address. A CPU sets up the configuration, the interrupt mask, the stack pointer and the message counter through a small register port, then issues a start command. The sequencer first marks the current entry as in progress. It then optionally stamps the time tag, fetches the data block address into an internal address register, and pulses the terminal engine to send the message.

When the engine reports end of message, the sequencer raises an interrupt and moves the stack pointer to the next entry. It also steps the message counter. It then either starts the next message, stops at the programmed message count, or halts after a faulty message when configured to stop on errors. The CPU can abort everything with a reset command. It can mask each interrupt source on its own and clear pending sources.

Top module: `bc_desc_seq`

## Requirements
- R1: Writing a word with bit 1 set to register 0 (command) starts the sequence when the sequencer is idle or halted. A start written while a message is in flight is ignored.
- R2: In the cycle after the start write, the block writes the start-of-message flag 16'h8000 to the block status word, at the address held in the stack pointer (register 3).
- R3: When configuration bit 1 (register 1) is set, the next memory cycle writes `ttag_i` to entry word 1. When that bit is clear, no time tag write occurs and entry word 1 is left untouched.
- R4: The block then reads entry word 3 (one-cycle read latency) into `data_addr_o`, followed by a one-cycle `eng_start_o` pulse. This is 4 cycles after the start write without a time tag and 5 cycles with one.
- R5: An `eom_i` pulse while waiting on the engine sets pending bit 0 (end of message). It adds 4 to the stack pointer and adds 1 to the message counter (register 4), wrapping from 16'hFFFF to 0.
- R6: When the incremented counter equals 16'hFFFF, pending bit 1 (done) is set and the sequencer returns to idle with no further memory access.
- R7: `eom_err_i` or `eom_tmo_i` at end of message sets pending bit 2 (format error). With configuration bit 0 (stop on error) set, the sequencer halts until a new start, which resumes at the advanced stack pointer. Otherwise the next entry is processed at once. Halt takes priority over done.
- R8: `irq_o` is high when some pending bit (register 5) is set and its mask bit (register 2, 1 = masked) is clear. Pending bits read back regardless of mask. Writing 1s to register 5 clears those bits.
- R9: Writing bit 0 of the command register returns the sequencer to idle, clears all pending bits and drops any memory request on the next cycle. It wins over a start in the same write.
- R10: `eom_i` outside the engine-wait state changes neither the pending bits, the stack pointer nor the counter.
- R11: After reset, all registers read 0, and `mem_req`, `eng_start_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register select (0 cmd, 1 cfg, 2 mask, 3 stack ptr, 4 counter, 5 pending) |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data for `cpu_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (0 = read) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read request |
| ttag_i | input | 16 | Current time tag value |
| eom_i | input | 1 | End-of-message pulse from the terminal engine |
| eom_err_i | input | 1 | Message error flag, qualified by `eom_i` |
| eom_tmo_i | input | 1 | Response timeout flag, qualified by `eom_i` |
| eng_start_o | output | 1 | One-cycle start pulse to the terminal engine |
| data_addr_o | output | 16 | Internal data block address register |
| irq_o | output | 1 | Unmasked interrupt request |

## Verification
The bench goes after the counter edge at 16'hFFFE. A design that tested the old counter value there would send one message too many, and one that missed the wrap from 16'hFFFF would raise done a full counter period late. It checks that stop on error without an error still continues, and that error without stop on error does not halt. A design that mixed these up would either freeze the bus or run past faulty messages. It also fires a start during a busy message and an end-of-message while idle. A design that honoured either would corrupt the stack pointer or re-stamp an entry. Finally it places a reset in the middle of the fetch sequence: a design that let the sequence finish would still pulse the engine.

// File: rtl/bcds_pkg.sv
package bcds_pkg;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NIRQ = 3;
    localparam int RAW = 3;

    localparam int ENTRY_STRIDE = 4;
    localparam int TTAG_OFS = 1;
    localparam int DBA_OFS = 3;
    localparam logic [DW-1:0] SOM_FLAG = 16'h8000;
    localparam logic [DW-1:0] CNT_LAST = {DW{1'b1}};

    localparam logic [RAW-1:0] REG_CMD  = 3'd0;
    localparam logic [RAW-1:0] REG_CFG  = 3'd1;
    localparam logic [RAW-1:0] REG_MASK = 3'd2;
    localparam logic [RAW-1:0] REG_SP   = 3'd3;
    localparam logic [RAW-1:0] REG_CNT  = 3'd4;
    localparam logic [RAW-1:0] REG_PEND = 3'd5;

    localparam int CMD_RESET = 0;
    localparam int CMD_START = 1;
    localparam int IRQ_EOM  = 0;
    localparam int IRQ_DONE = 1;
    localparam int IRQ_FMT  = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SOM, ST_TTAG, ST_RDBA, ST_WDBA, ST_GO, ST_BUSY, ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic ttag_en;
        logic stop_on_err;
    } cfg_t;

    typedef struct packed {
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } mem_cmd_t;

    function automatic logic [AW-1:0] entry_word(input logic [AW-1:0] base, input int ofs);
        return base + AW'(ofs);
    endfunction
endpackage

// File: rtl/bcds_regs.sv
module bcds_regs
    import bcds_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_wr,
    input  logic [RAW-1:0]  cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    input  logic [NIRQ-1:0] pend_i,
    input  logic            adv_i,
    output cfg_t            cfg_o,
    output logic [NIRQ-1:0] mask_o,
    output logic [AW-1:0]   sp_o,
    output logic [DW-1:0]   cnt_o,
    output logic            start_cmd_o,
    output logic            rst_cmd_o,
    output logic [NIRQ-1:0] ack_o
);
    cfg_t            cfg_q;
    logic [NIRQ-1:0] mask_q;
    logic [AW-1:0]   sp_q;
    logic [DW-1:0]   cnt_q;
    logic            cmd_wr;

    assign cmd_wr      = cpu_wr && (cpu_addr == REG_CMD);
    assign rst_cmd_o   = cmd_wr && cpu_wdata[CMD_RESET];
    assign start_cmd_o = cmd_wr && cpu_wdata[CMD_START] && !cpu_wdata[CMD_RESET];
    assign ack_o       = (cpu_wr && cpu_addr == REG_PEND) ? cpu_wdata[NIRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '0;
            sp_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (cpu_wr) begin
                case (cpu_addr)
                    REG_CFG:  cfg_q  <= cfg_t'(cpu_wdata[1:0]);
                    REG_MASK: mask_q <= cpu_wdata[NIRQ-1:0];
                    REG_SP:   sp_q   <= cpu_wdata[AW-1:0];
                    REG_CNT:  cnt_q  <= cpu_wdata;
                    default: ;
                endcase
            end
            if (adv_i) begin
                sp_q  <= entry_word(sp_q, ENTRY_STRIDE);
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        case (cpu_addr)
            REG_CFG:  cpu_rdata = DW'(cfg_q);
            REG_MASK: cpu_rdata = DW'(mask_q);
            REG_SP:   cpu_rdata = DW'(sp_q);
            REG_CNT:  cpu_rdata = cnt_q;
            REG_PEND: cpu_rdata = DW'(pend_i);
            default:  cpu_rdata = '0;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign mask_o = mask_q;
    assign sp_o   = sp_q;
    assign cnt_o  = cnt_q;

    // R5: stack pointer steps one entry per completed message
    p_sp_advance_r5: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> sp_q == $past(sp_q) + AW'(ENTRY_STRIDE));
    // R5: counter steps by one with natural wrap
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/bcds_irq.sv
module bcds_irq
    import bcds_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NIRQ-1:0] set_i,
    input  logic [NIRQ-1:0] ack_i,
    input  logic            clr_all_i,
    input  logic [NIRQ-1:0] mask_i,
    output logic [NIRQ-1:0] pend_o,
    output logic            irq_o
);
    logic [NIRQ-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst || clr_all_i) pend_q <= '0;
        else                  pend_q <= (pend_q & ~ack_i) | set_i;
    end

    assign pend_o = pend_q;
    assign irq_o  = |(pend_q & ~mask_i);

    // R9: reset command empties every pending source
    p_clear_all_r9: assert property (@(posedge clk) disable iff (rst)
        clr_all_i |=> pend_q == '0);
    // R8: a source raised this cycle survives into the next
    p_set_sticks_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr_all_i && set_i != '0) |=> (pend_q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/bcds_walker.sv
module bcds_walker
    import bcds_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_cmd_i,
    input  logic            rst_cmd_i,
    input  cfg_t            cfg_i,
    input  logic [AW-1:0]   sp_i,
    input  logic [DW-1:0]   cnt_i,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic [DW-1:0]   ttag_i,
    input  logic            eom_i,
    input  logic            eom_err_i,
    input  logic            eom_tmo_i,
    output mem_cmd_t        mem_o,
    output logic [AW-1:0]   data_addr_o,
    output logic            eng_start_o,
    output logic            adv_o,
    output logic [NIRQ-1:0] irq_set_o
);
    seq_state_e    state_q, state_d;
    logic [AW-1:0] entry_q;
    logic [AW-1:0] dba_q;
    logic          eom_fire, bad_msg, last_msg, can_start;

    assign eom_fire  = (state_q == ST_BUSY) && eom_i;
    assign bad_msg   = eom_err_i || eom_tmo_i;
    assign last_msg  = (cnt_i + 1'b1) == CNT_LAST;
    assign can_start = start_cmd_i && (state_q == ST_IDLE || state_q == ST_HALT);

    always_comb begin
        irq_set_o = '0;
        irq_set_o[IRQ_EOM]  = eom_fire;
        irq_set_o[IRQ_DONE] = eom_fire && last_msg;
        irq_set_o[IRQ_FMT]  = eom_fire && bad_msg;
    end
    assign adv_o = eom_fire;

    always_comb begin
        mem_o       = '0;
        eng_start_o = 1'b0;
        case (state_q)
            ST_SOM: begin
                mem_o.req   = 1'b1;
                mem_o.we    = 1'b1;
                mem_o.addr  = entry_q;
                mem_o.wdata = SOM_FLAG;
            end
            ST_TTAG: begin
                mem_o.req   = 1'b1;
                mem_o.we    = 1'b1;
                mem_o.addr  = entry_word(entry_q, TTAG_OFS);
                mem_o.wdata = ttag_i;
            end
            ST_RDBA: begin
                mem_o.req  = 1'b1;
                mem_o.addr = entry_word(entry_q, DBA_OFS);
            end
            ST_GO:   eng_start_o = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_HALT: if (can_start) state_d = ST_SOM;
            ST_SOM:  state_d = cfg_i.ttag_en ? ST_TTAG : ST_RDBA;
            ST_TTAG: state_d = ST_RDBA;
            ST_RDBA: state_d = ST_WDBA;
            ST_WDBA: state_d = ST_GO;
            ST_GO:   state_d = ST_BUSY;
            ST_BUSY: if (eom_fire) begin
                if (bad_msg && cfg_i.stop_on_err) state_d = ST_HALT;
                else if (last_msg)                state_d = ST_IDLE;
                else                              state_d = ST_SOM;
            end
            default: state_d = ST_IDLE;
        endcase
        if (rst_cmd_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            entry_q <= '0;
            dba_q   <= '0;
        end else begin
            state_q <= state_d;
            if (can_start && !rst_cmd_i) entry_q <= sp_i;
            else if (eom_fire)           entry_q <= entry_word(sp_i, ENTRY_STRIDE);
            if (state_q == ST_WDBA)      dba_q   <= mem_rdata_i;
        end
    end

    assign data_addr_o = dba_q;

    // R4: engine start lasts exactly one cycle
    p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o);
    // R4: the engine is started only after the address fetch two cycles earlier
    p_dba_read_first_r4: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> $past(mem_o.req && !mem_o.we, 2));
    // R7: a halted sequencer stays put until a command arrives
    p_halt_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && !start_cmd_i && !rst_cmd_i) |=> state_q == ST_HALT);
    // R9: reset command drops memory traffic on the next cycle
    p_reset_drops_mem_r9: assert property (@(posedge clk) disable iff (rst)
        rst_cmd_i |=> !mem_o.req && !eng_start_o);
endmodule

// File: rtl/bc_desc_seq.sv
module bc_desc_seq
    import bcds_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_wr,
    input  logic [2:0]    cpu_addr,
    input  logic [15:0]   cpu_wdata,
    output logic [15:0]   cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    input  logic [15:0]   ttag_i,
    input  logic          eom_i,
    input  logic          eom_err_i,
    input  logic          eom_tmo_i,
    output logic          eng_start_o,
    output logic [15:0]   data_addr_o,
    output logic          irq_o
);
    cfg_t            cfg;
    logic [NIRQ-1:0] mask, pend, ack, irq_set;
    logic [AW-1:0]   sp;
    logic [DW-1:0]   cnt;
    logic            start_cmd, rst_cmd, adv;
    mem_cmd_t        mem_cmd;

    bcds_regs u_regs (
        .clk(clk), .rst(rst),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pend_i(pend), .adv_i(adv),
        .cfg_o(cfg), .mask_o(mask), .sp_o(sp), .cnt_o(cnt),
        .start_cmd_o(start_cmd), .rst_cmd_o(rst_cmd), .ack_o(ack)
    );

    bcds_walker u_walker (
        .clk(clk), .rst(rst),
        .start_cmd_i(start_cmd), .rst_cmd_i(rst_cmd), .cfg_i(cfg),
        .sp_i(sp), .cnt_i(cnt), .mem_rdata_i(mem_rdata), .ttag_i(ttag_i),
        .eom_i(eom_i), .eom_err_i(eom_err_i), .eom_tmo_i(eom_tmo_i),
        .mem_o(mem_cmd), .data_addr_o(data_addr_o), .eng_start_o(eng_start_o),
        .adv_o(adv), .irq_set_o(irq_set)
    );

    bcds_irq u_irq (
        .clk(clk), .rst(rst),
        .set_i(irq_set), .ack_i(ack), .clr_all_i(rst_cmd), .mask_i(mask),
        .pend_o(pend), .irq_o(irq_o)
    );

    assign mem_req   = mem_cmd.req;
    assign mem_we    = mem_cmd.we;
    assign mem_addr  = mem_cmd.addr;
    assign mem_wdata = mem_cmd.wdata;

    // R6: done is raised only as the counter lands on its final value
    p_done_at_limit_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[IRQ_DONE]) |-> cnt == CNT_LAST);
endmodule

// File: tb/bc_desc_seq_tb.sv
module bc_desc_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_wr = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] ttag_i = '0;
    logic eom_i = 1'b0, eom_err_i = 1'b0, eom_tmo_i = 1'b0;
    logic eng_start_o;
    logic [15:0] data_addr_o;
    logic irq_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [0:63];

    always #2 clk = ~clk;

    bc_desc_seq dut_i (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ttag_i(ttag_i), .eom_i(eom_i),
        .eom_err_i(eom_err_i), .eom_tmo_i(eom_tmo_i), .eng_start_o(eng_start_o),
        .data_addr_o(data_addr_o), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[5:0]];
        end
    end

    // {ttag_en, stop_on_err, err, tmo, data block address}
    localparam logic [19:0] VECS [0:5] = '{
        20'h00A00, 20'h80B10, 20'h60C20, 20'hD0D30, 20'h20E40, 20'hC0F50
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic pulse_eom(input logic e, input logic t);
        eom_i = 1'b1; eom_err_i = e; eom_tmo_i = t;
        @(negedge clk);
        eom_i = 1'b0; eom_err_i = 1'b0; eom_tmo_i = 1'b0;
    endtask

    task automatic wait_eng(output int n);
        n = 1;
        while (!eng_start_o && n < 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v, sp0;
        int n;
        for (int k = 0; k < 64; k++) mem[k] = 16'hDEAD;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk("R11 mem_req", mem_req, 0);
        chk("R11 eng_start", eng_start_o, 0);
        chk("R11 irq", irq_o, 0);
        for (int a = 1; a < 6; a++) begin
            rd(a[2:0], v);
            chk("R11 reg zero", v, 0);
        end

        for (int i = 0; i < 6; i++) begin
            logic tt, stp, er, tm, bad;
            logic [15:0] dba, sp;
            {tt, stp, er, tm, dba} = VECS[i];
            bad = er | tm;
            sp = 16'(8 * i);
            cpu_write(3'd0, 16'h0001);
            cpu_write(3'd1, {14'd0, tt, stp});
            cpu_write(3'd2, 16'h0000);
            cpu_write(3'd3, sp);
            cpu_write(3'd4, 16'h0100);
            mem[sp[5:0]] = 16'h0000;
            mem[sp[5:0] + 1] = 16'hDEAD;
            mem[sp[5:0] + 3] = dba;
            ttag_i = 16'h1000 + 16'(i);
            cpu_write(3'd0, 16'h0002);
            // R1 / R2: start begins with SOM write at stack pointer
            chk("R2 som req", {mem_req, mem_we}, 2'b11);
            chk("R2 som addr", mem_addr, sp);
            chk("R2 som data", mem_wdata, 16'h8000);
            wait_eng(n);
            chk("R4 start latency", n, tt ? 5 : 4);
            chk("R4 data_addr", data_addr_o, dba);
            chk("R2 status word", mem[sp[5:0]], 16'h8000);
            chk("R3 time tag word", mem[sp[5:0] + 1], tt ? ttag_i : 16'hDEAD);
            @(negedge clk);
            chk("R4 start one cycle", eng_start_o, 0);
            pulse_eom(er, tm);
            if (bad && stp) begin
                chk("R7 halted no req", mem_req, 0);
            end else begin
                chk("R7 continue req", mem_req, 1);
                chk("R5 next entry", mem_addr, sp + 16'd4);
            end
            rd(3'd5, v);
            chk("R5 R7 pending", v, {13'd0, bad, 1'b0, 1'b1});
            chk("R8 irq unmasked", irq_o, 1);
            rd(3'd3, v);
            chk("R5 sp step", v, sp + 16'd4);
            rd(3'd4, v);
            chk("R5 count step", v, 16'h0101);
            if (bad && stp) begin
                repeat (3) @(negedge clk);
                chk("R7 still halted", mem_req, 0);
                cpu_write(3'd0, 16'h0002);
                chk("R7 resume req", {mem_req, mem_we}, 2'b11);
                chk("R7 resume addr", mem_addr, sp + 16'd4);
            end
        end

        // R6: counter reaching FFFF ends the run
        cpu_write(3'd0, 16'h0001);
        cpu_write(3'd1, 16'h0000);
        cpu_write(3'd3, 16'h0000);
        cpu_write(3'd4, 16'hFFFE);
        mem[3] = 16'h1234;
        cpu_write(3'd0, 16'h0002);
        wait_eng(n);
        @(negedge clk);
        pulse_eom(1'b0, 1'b0);
        chk("R6 stops", mem_req, 0);
        rd(3'd5, v);
        chk("R6 done pending", v, 16'h0003);
        rd(3'd4, v);
        chk("R6 count final", v, 16'hFFFF);
        repeat (3) @(negedge clk);
        chk("R6 stays idle", {mem_req, eng_start_o}, 2'b00);

        // R8: masking and write-one-to-clear
        cpu_write(3'd2, 16'h0003);
        chk("R8 all masked", irq_o, 0);
        cpu_write(3'd2, 16'h0001);
        chk("R8 done unmasked", irq_o, 1);
        cpu_write(3'd5, 16'h0002);
        rd(3'd5, v);
        chk("R8 w1c", v, 16'h0001);
        chk("R8 eom masked", irq_o, 0);

        // R5: counter wrap from FFFF, no done
        cpu_write(3'd0, 16'h0001);
        cpu_write(3'd4, 16'hFFFF);
        cpu_write(3'd3, 16'h0000);
        cpu_write(3'd0, 16'h0002);
        wait_eng(n);
        @(negedge clk);
        pulse_eom(1'b0, 1'b0);
        chk("R5 wrap continues", mem_req, 1);
        rd(3'd4, v);
        chk("R5 wrap count", v, 16'h0000);
        rd(3'd5, v);
        chk("R5 wrap pending", v, 16'h0001);

        // R1: start while busy is ignored
        cpu_write(3'd0, 16'h0001);
        cpu_write(3'd3, 16'h0000);
        cpu_write(3'd4, 16'h0000);
        cpu_write(3'd0, 16'h0002);
        wait_eng(n);
        @(negedge clk);
        cpu_write(3'd0, 16'h0002);
        chk("R1 busy start ignored", mem_req, 0);
        repeat (2) @(negedge clk);
        chk("R1 still busy", {mem_req, eng_start_o}, 2'b00);

        // R10: eom outside engine wait is ignored
        cpu_write(3'd0, 16'h0001);
        rd(3'd3, sp0);
        @(negedge clk);
        pulse_eom(1'b1, 1'b1);
        rd(3'd5, v);
        chk("R10 pending untouched", v, 16'h0000);
        rd(3'd3, v);
        chk("R10 sp untouched", v, sp0);
        rd(3'd4, v);
        chk("R10 count untouched", v, 16'h0000);

        // R9: reset command mid-sequence, winning over start
        cpu_write(3'd1, 16'h0002);
        cpu_write(3'd0, 16'h0002);
        cpu_write(3'd0, 16'h0003);
        chk("R9 mem dropped", mem_req, 0);
        n = 0;
        for (int c = 0; c < 8; c++) begin
            if (eng_start_o || mem_req) n++;
            @(negedge clk);
        end
        chk("R9 no engine start", n, 0);

        finish_run();
    end
endmodule